// File: doc/BRIEF.md
# Winding Current Chopper with Selectable Off-Time and Mixed Decay

This block controls one motor winding bridge with a fixed off-time current chopper. Each chop cycle begins with the bridge driving current into the winding. A blanking window masks the current comparator while switching noise settles. Once that window has passed, the first comparator trip ends the drive phase. The block then holds the bridge off the supply for a fixed off-time. The off-time comes from a three-level select. The off-time opens with fast decay for a selectable fraction (none, a quarter, a half or all of it), and slow decay covers the rest. Every change of bridge state is separated by a dead-time gap in which all switches are off.

The bridge command is a two-bit code for drive, fast decay or slow decay, together with an all-off flag. The flag is high during dead time and while the block is disabled. All timings are counted in system clock cycles and set by parameters. At a 50 MHz clock the defaults give 1400, 760 and 405 cycles of off-time, 35 cycles of blanking and 40 cycles of dead time. The off-time and decay selects are sampled once per chop, at the comparator trip.

Top module: `coil_chopper`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, `bridge_o` is 2'b00 (drive) and `dead_o` is 0. The blanking window of `T_BLANK` cycles starts counting at that point.
- R2: In drive, once dead time and blanking are over, a high `trip_i` sampled at a clock edge switches `bridge_o` to an off state from the next cycle. While `trip_i` stays low, the bridge stays in drive indefinitely.
- R3: `trip_i` is ignored during the dead time and during the `T_BLANK` cycles that follow the start of every drive phase.
- R4: The conducting length of an off period, with dead time excluded, is `T_OFF_LO` cycles for `toff_sel_i` = 2'b00, `T_OFF_MID` for 2'b01, `T_OFF_HI` for 2'b10, and `T_OFF_MID` for 2'b11.
- R5: The fast-decay length is floor(total/4) for `decay_sel_i` = 2'b01, floor(total/2) for 2'b10, and the whole off-time for 2'b11. For 2'b00 it is zero, and the off period is all slow decay.
- R6: Within an off period, fast decay (`bridge_o` = 2'b01) comes first and slow decay (`bridge_o` = 2'b10) follows. The code 2'b11 never appears.
- R7: Every change of `bridge_o` is followed by exactly `T_DEAD` cycles with `dead_o` high, starting in the cycle in which the new code appears. Phase timers do not advance during this gap.
- R8: `disable_i` drives `dead_o` high in the same cycle, without waiting for a clock edge, and forces `bridge_o` to drive. After release, the block restarts a drive phase with `T_BLANK` cycles of blanking and no dead time.
- R9: `toff_sel_i` and `decay_sel_i` are sampled only at the edge where the trip is accepted. A change made during an off period takes effect on the next chop.
- R10: When the off-time expires, `bridge_o` returns to drive with dead time, followed by a fresh blanking window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| disable_i | input | 1 | Forces all switches off and restarts from drive when released |
| trip_i | input | 1 | Comparator flag: winding current reached the set-point |
| toff_sel_i | input | 2 | Off-time select: 00 long, 01 middle, 10 short, 11 middle |
| decay_sel_i | input | 2 | Fast-decay fraction: 00 none, 01 quarter, 10 half, 11 full |
| bridge_o | output | 2 | Bridge command: 00 drive, 01 fast decay, 10 slow decay |
| dead_o | output | 1 | All switches off (dead time or disabled) |

## Verification
A new `bridge_o` code appears in the cycle after the edge that decides it. `dead_o` follows a `disable_i` change within the same cycle, and a dead-time gap starts in the same cycle as the new bridge code. The bench keeps a behavioural model that counts cycles elapsed in each phase and updates it at every rising edge. It compares both outputs against that model a quarter period after each edge, so every registered result has settled and the combinational disable path is already visible. Stimulus changes only at falling edges. Scenarios walk through all sixteen select combinations, hold the trip low past blanking, change the selects mid-off-period, and pulse the disable input during fast decay and during dead time.

// File: rtl/chop_pkg.sv
package chop_pkg;

    localparam int PLAN_W = 16;

    typedef enum logic [1:0] {
        BR_DRIVE = 2'b00,
        BR_FAST  = 2'b01,
        BR_SLOW  = 2'b10
    } bridge_e;

    typedef struct packed {
        logic [PLAN_W-1:0] total;
        logic [PLAN_W-1:0] fast;
    } off_plan_t;

    function automatic logic [PLAN_W-1:0] fast_share(input logic [PLAN_W-1:0] t,
                                                     input logic [1:0] dsel);
        case (dsel)
            2'b01:   fast_share = t >> 2;
            2'b10:   fast_share = t >> 1;
            2'b11:   fast_share = t;
            default: fast_share = '0;
        endcase
    endfunction

endpackage

// File: rtl/chop_sel_decode.sv
module chop_sel_decode
    import chop_pkg::*;
#(
    parameter int T_OFF_LO  = 1400,
    parameter int T_OFF_MID = 760,
    parameter int T_OFF_HI  = 405
) (
    input  logic [1:0] toff_sel,
    input  logic [1:0] decay_sel,
    output off_plan_t  plan
);
    logic [PLAN_W-1:0] total;

    always_comb begin
        case (toff_sel)
            2'b00:   total = PLAN_W'(T_OFF_LO);
            2'b10:   total = PLAN_W'(T_OFF_HI);
            default: total = PLAN_W'(T_OFF_MID);
        endcase
        plan.total = total;
        plan.fast  = fast_share(total, decay_sel);
    end
endmodule

// File: rtl/chop_dead_gen.sv
module chop_dead_gen #(
    parameter int T_DEAD = 40
) (
    input  logic clk,
    input  logic clr,
    input  logic start,
    output logic busy
);
    localparam int DW = (T_DEAD < 1) ? 1 : $clog2(T_DEAD + 1);

    logic [DW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (clr)
            cnt <= '0;
        else if (start)
            cnt <= DW'(T_DEAD);
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);
endmodule

// File: rtl/coil_chopper.sv
module coil_chopper
    import chop_pkg::*;
#(
    parameter int T_OFF_LO  = 1400,
    parameter int T_OFF_MID = 760,
    parameter int T_OFF_HI  = 405,
    parameter int T_BLANK   = 35,
    parameter int T_DEAD    = 40
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       disable_i,
    input  logic       trip_i,
    input  logic [1:0] toff_sel_i,
    input  logic [1:0] decay_sel_i,
    output logic [1:0] bridge_o,
    output logic       dead_o
);
    localparam int BW = (T_BLANK < 1) ? 1 : $clog2(T_BLANK + 1);
    localparam logic [BW-1:0] BLANK_INIT = BW'(T_BLANK);

    bridge_e           mode_q, mode_d;
    logic [BW-1:0]     blank_q, blank_d;
    logic [PLAN_W-1:0] off_q, off_d, fast_q, fast_d;
    off_plan_t         plan;
    logic              dead_busy, dead_start;

    chop_sel_decode #(
        .T_OFF_LO (T_OFF_LO),
        .T_OFF_MID(T_OFF_MID),
        .T_OFF_HI (T_OFF_HI)
    ) u_dec (
        .toff_sel (toff_sel_i),
        .decay_sel(decay_sel_i),
        .plan     (plan)
    );

    always_comb begin
        mode_d  = mode_q;
        blank_d = blank_q;
        off_d   = off_q;
        fast_d  = fast_q;
        if (!dead_busy) begin
            case (mode_q)
                BR_DRIVE: begin
                    if (blank_q != '0) begin
                        blank_d = blank_q - 1'b1;
                    end else if (trip_i) begin
                        off_d  = plan.total;
                        fast_d = plan.fast;
                        mode_d = (plan.fast != '0) ? BR_FAST : BR_SLOW;
                    end
                end
                BR_FAST: begin
                    off_d  = off_q - 1'b1;
                    fast_d = fast_q - 1'b1;
                    if (off_q == PLAN_W'(1)) begin
                        mode_d  = BR_DRIVE;
                        blank_d = BLANK_INIT;
                    end else if (fast_q == PLAN_W'(1)) begin
                        mode_d = BR_SLOW;
                    end
                end
                BR_SLOW: begin
                    if (off_q == PLAN_W'(1)) begin
                        mode_d  = BR_DRIVE;
                        blank_d = BLANK_INIT;
                    end else begin
                        off_d = off_q - 1'b1;
                    end
                end
                default: mode_d = BR_DRIVE;
            endcase
        end
    end

    assign dead_start = (mode_d != mode_q) && !disable_i;

    always_ff @(posedge clk) begin
        if (rst || disable_i) begin
            mode_q  <= BR_DRIVE;
            blank_q <= BLANK_INIT;
            off_q   <= '0;
            fast_q  <= '0;
        end else begin
            mode_q  <= mode_d;
            blank_q <= blank_d;
            off_q   <= off_d;
            fast_q  <= fast_d;
        end
    end

    chop_dead_gen #(.T_DEAD(T_DEAD)) u_dead (
        .clk  (clk),
        .clr  (rst || disable_i),
        .start(dead_start),
        .busy (dead_busy)
    );

    assign bridge_o = mode_q;
    assign dead_o   = disable_i | dead_busy;

    // R6: only the three legal bridge codes ever appear
    assert_legal_code_R6: assert property (@(posedge clk) disable iff (rst)
        bridge_o != 2'b11);

    // R6: slow decay is never followed by fast decay
    assert_fast_first_R6: assert property (@(posedge clk) disable iff (rst)
        ($past(mode_q) == BR_SLOW) |-> (mode_q != BR_FAST));

    // R2: leaving drive requires an accepted comparator trip
    assert_trip_ends_drive_R2: assert property (@(posedge clk) disable iff (rst)
        ($past(mode_q) == BR_DRIVE && mode_q != BR_DRIVE) |-> $past(trip_i));

    // R7: a new bridge code is always accompanied by the all-off gap
    assert_dead_on_change_R7: assert property (@(posedge clk) disable iff (rst)
        (!$past(disable_i) && mode_q != $past(mode_q)) |-> dead_o);

    // R8: after a disabled cycle the bridge is back at drive
    assert_disable_restart_R8: assert property (@(posedge clk) disable iff (rst)
        $past(disable_i) |-> (mode_q == BR_DRIVE));
endmodule

// File: tb/coil_chopper_tb.sv
module coil_chopper_tb;
    localparam int CLK_PERIOD = 10;
    localparam int TLO = 1400, TMID = 760, THI = 405, TB = 35, TD = 40;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       dis = 1'b0;
    logic       trip = 1'b0;
    logic [1:0] tsel = 2'b00;
    logic [1:0] dsel = 2'b00;
    logic [1:0] bridge;
    logic       dead;

    int    n_total = 0, n_bad = 0, cyc = 0;
    string scen = "R1";

    coil_chopper #(
        .T_OFF_LO(TLO), .T_OFF_MID(TMID), .T_OFF_HI(THI),
        .T_BLANK(TB), .T_DEAD(TD)
    ) u_dut (
        .clk(clk), .rst(rst), .disable_i(dis), .trip_i(trip),
        .toff_sel_i(tsel), .decay_sel_i(dsel),
        .bridge_o(bridge), .dead_o(dead)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference: elapsed-cycle counters per phase
    int m_off = 0;      // 0 drive, 1 off
    int m_t = TD;       // edges since drive began
    int m_e = 0;        // edges since trip accepted
    int m_F = 0, m_S = 0;
    int chops = 0;

    function automatic int ref_total(input logic [1:0] s);
        if (s == 2'b00) return TLO;
        if (s == 2'b10) return THI;
        return TMID;
    endfunction

    function automatic int ref_fast(input int t, input logic [1:0] d);
        case (d)
            2'b01: return t / 4;
            2'b10: return t / 2;
            2'b11: return t;
            default: return 0;
        endcase
    endfunction

    function automatic int off_len();
        if (m_F == 0) return TD + m_S;
        if (m_S == 0) return TD + m_F;
        return 2*TD + m_F + m_S;
    endfunction

    always @(posedge clk) begin
        if (rst || dis) begin
            m_off = 0; m_t = TD;
        end else if (m_off == 0) begin
            if (m_t >= TD + TB && trip) begin
                m_off = 1; m_e = 0;
                m_F = ref_fast(ref_total(tsel), dsel);
                m_S = ref_total(tsel) - m_F;
                chops++;
            end else m_t++;
        end else begin
            if (m_e + 1 == off_len()) begin m_off = 0; m_t = 0; end
            else m_e++;
        end
    end

    task automatic expect_now(output logic [1:0] eb, output logic ed, output string tag);
        if (m_off == 0) begin
            eb = 2'b00; ed = (m_t < TD);
            tag = ed ? "R7 R10" : (m_t < TD + TB) ? "R3" : "R2";
        end else if (m_F > 0 && m_e < TD + m_F) begin
            eb = 2'b01; ed = (m_e < TD); tag = ed ? "R7" : "R5 R6";
        end else begin
            int base = (m_F > 0) ? TD + m_F : 0;
            eb = 2'b10; ed = (m_e < base + TD); tag = ed ? "R7" : "R4 R6";
        end
        if (dis) begin ed = 1'b1; tag = "R8"; end
    endtask

    always @(posedge clk) begin
        #(CLK_PERIOD/4);
        if (!rst) begin
            logic [1:0] eb; logic ed; string tag;
            expect_now(eb, ed, tag);
            n_total++;
            if (bridge !== eb || dead !== ed) begin
                n_bad++;
                if (n_bad < 20)
                    $display("FAIL %s [%s] cyc=%0d bridge=%b dead=%b expected bridge=%b dead=%b",
                             tag, scen, cyc, bridge, dead, eb, ed);
            end
        end
    end

    task automatic wait_chop_end();
        while (m_off == 0) @(negedge clk);
        while (m_off == 1) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        trip = 1'b1;            // trip held high across reset: R3 blanking test
        rst = 1'b0;
        scen = "R1";
        @(negedge clk);
        scen = "R3";
        wait_chop_end();
        for (int t = 0; t < 4; t++) begin
            for (int d = 0; d < 4; d++) begin
                tsel = t[1:0]; dsel = d[1:0];
                scen = "R4 R5";
                wait_chop_end();
            end
        end
        // no trip: drive persists past blanking
        trip = 1'b0; scen = "R2";
        repeat (300) @(negedge clk);
        trip = 1'b1;
        // select change during an off period applies to next chop
        tsel = 2'b10; dsel = 2'b01; scen = "R9";
        while (m_off == 0) @(negedge clk);
        repeat (TD + 20) @(negedge clk);
        tsel = 2'b00; dsel = 2'b10;
        wait_chop_end();
        wait_chop_end();
        // disable during fast decay
        dsel = 2'b11; scen = "R8";
        while (!(m_off == 1 && m_e == TD + 5)) @(negedge clk);
        dis = 1'b1;
        repeat (10) @(negedge clk);
        dis = 1'b0;
        // disable during drive dead time
        wait_chop_end();
        repeat (5) @(negedge clk);
        dis = 1'b1;
        @(negedge clk);
        dis = 1'b0;
        wait_chop_end();
        repeat (20) @(negedge clk);
        n_total++;
        if (chops < 20) begin
            n_bad++;
            $display("FAIL R2 chop count actual=%0d expected>=20", chops);
        end
        $display("test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog R2 actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", n_total, n_bad);
            $finish;
        end
    end
endmodule